// File: doc/BRIEF.md
# Multicast Word-Update Packet Builder

This block turns one line-update descriptor into a series of write packets, one for each L1 cache that holds a copy of the line. It then waits for the single-flit acknowledgements from those caches. A descriptor carries the following:

- the line index
- the index of the first modified word
- a word count N from 1 to 16
- the modified words in order, each with its own byte-enable nibble
- a transaction index
- an ordered list of target IDs

Each packet is N+2 flits long. Two header flits come first: the line index, then the start-word index. The N payload words follow.

The owner pulses `start` while the block is idle. The block then streams flits on a valid/ready interface. Targets are served in list order, and each packet starts as soon as the previous one is accepted. The block counts acknowledgements on `rsp_valid` and pulses `done` once every packet has left and one acknowledgement has come back for each target. After `done` it is idle again. The directory lookup that chooses the targets, and the routing of flits, sit outside this block.

Top module: `mcast_upd_builder`

## Requirements
- R1: After reset `flit_valid`, `busy` and `done` are 0. A response pulse while idle has no effect: `done` stays 0 and the next descriptor completes after exactly its own number of responses.
- R2: A `start` pulse while idle captures the descriptor and raises `busy`. The first flit is valid on the next cycle. A `start` while busy is ignored, and the packets in progress keep the captured fields.
- R3: Each packet is N+2 flits. `flit_wdata` carries the following, zero-extended where needed:
    - flit 0: the 30-bit line index
    - flit 1: the 4-bit first-word index
    - flits 2..N+1: descriptor words 0..N-1 in order
- R4: On every flit the following fields are fixed:
    - `flit_plen` = 4*N
    - `flit_cmd` = 2'b10 (write)
    - `flit_addr` = parameter `UPD_ADDR`
    - `flit_trdid` = the captured transaction index
- R5: The two header flits carry byte enables 4'hF. Payload flit k carries descriptor byte-enable nibble k-2, and 4'h0 is passed through unchanged.
- R6: `flit_eop` is 1 only on flit N+1 of each packet.
- R7: While `flit_valid` is 1 and `flit_ready` is 0, every flit output holds its value.
- R8: One packet is sent per target, in list order (target 0 first), with `flit_tgt` set to that target's ID. With `flit_ready` held at 1, `flit_valid` stays 1 from the first flit of the first packet through the last flit of the last packet.
- R9: Responses are counted only while busy. `done` is a one-cycle pulse, raised one cycle after all packets have been accepted and the response count has reached the target count. `busy` falls in the same cycle that `done` rises. `done` never rises before the last response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Descriptor strobe, taken only when idle |
| desc_line | input | LINE_W | Line index |
| desc_first | input | log2(MAX_WORDS) | Index of first modified word |
| desc_nwords | input | log2(MAX_WORDS+1) | Modified word count N (1..MAX_WORDS) |
| desc_data | input | MAX_WORDS*WORD_W | Modified words, word 0 in the low bits |
| desc_be | input | MAX_WORDS*WORD_W/8 | Byte enables per word, word 0 in the low bits |
| desc_trid | input | TRID_W | Transaction index |
| desc_ntgt | input | log2(MAX_TGT+1) | Number of targets (1..MAX_TGT) |
| desc_tgts | input | MAX_TGT*TGT_W | Target IDs, target 0 in the low bits |
| busy | output | 1 | Descriptor in progress |
| done | output | 1 | One-cycle completion pulse |
| flit_valid | output | 1 | Flit valid |
| flit_ready | input | 1 | Flit accepted by network |
| flit_addr | output | ADDR_W | Update register address |
| flit_cmd | output | 2 | Command code |
| flit_plen | output | log2(4*MAX_WORDS+1) | Packet length in bytes |
| flit_trdid | output | TRID_W | Transaction index |
| flit_tgt | output | TGT_W | Destination cache ID |
| flit_wdata | output | WORD_W | Flit data |
| flit_be | output | WORD_W/8 | Flit byte enables |
| flit_eop | output | 1 | Last flit of packet |
| rsp_valid | input | 1 | One acknowledgement from a target |

## Verification
If the flit or target counter went wrong inside this block, the flit stream would show it at once. A header would appear where a payload word was expected, `flit_eop` would fall on the wrong flit, or a target ID would be repeated or skipped. The bench compares each accepted flit against values it computes itself, so such an error shows within a flit.

If the response counter or completion logic went wrong, `done` would rise early or never. The bench checks `done` before and after every response. The sweep covers every word count from 1 to 16 with every target count from 1 to 4, runs each pairing both with full-rate and stalled acceptance, and includes byte-enable patterns of zero.

// File: rtl/mub_pkg.sv
// Package: shared constants for the multicast update packet builder.
// Assumes a two-bit command encoding in which 2'b10 means write.
package mub_pkg;
    localparam logic [1:0] CMD_WRITE = 2'b10;
    localparam int HDR_FLITS = 2;
endpackage

// File: rtl/mub_flit_seq.sv
// Module: flit and target sequencer.
// Walks flit index 0..N+1 for each target in turn and advances on every
// accepted flit. Assumes n_words and n_tgts are constant while sending
// and that both are at least 1.
module mub_flit_seq #(
    parameter int MAX_WORDS = 16,
    parameter int MAX_TGT   = 4,
    localparam int CNT_W = $clog2(MAX_WORDS + 1),
    localparam int FW    = $clog2(MAX_WORDS + 2),
    localparam int TCW   = $clog2(MAX_TGT + 1),
    localparam int TIW   = (MAX_TGT > 1) ? $clog2(MAX_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             fire,
    input  logic [CNT_W-1:0] n_words,
    input  logic [TCW-1:0]   n_tgts,
    output logic             sending,
    output logic [FW-1:0]    flit_idx,
    output logic [TIW-1:0]   tgt_idx,
    output logic             last_flit
);
    logic last_tgt;

    // Decode end of packet and end of target list.
    always_comb begin
        last_flit = (flit_idx == FW'(n_words) + FW'(mub_pkg::HDR_FLITS - 1));
        last_tgt  = (TCW'(tgt_idx) == n_tgts - TCW'(1));
    end

    // Advance flit index, then target index, on each accepted flit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sending  <= 1'b0;
            flit_idx <= '0;
            tgt_idx  <= '0;
        end else if (load) begin
            sending  <= 1'b1;
            flit_idx <= '0;
            tgt_idx  <= '0;
        end else if (sending && fire) begin
            if (last_flit) begin
                flit_idx <= '0;
                if (last_tgt) sending <= 1'b0;
                else          tgt_idx <= tgt_idx + TIW'(1);
            end else begin
                flit_idx <= flit_idx + FW'(1);
            end
        end
    end

    AST_IDX_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        sending |-> (flit_idx <= FW'(n_words) + FW'(1))) else $error("flit index past end"); // R3
    AST_TGT_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
        sending |-> (TCW'(tgt_idx) < n_tgts)) else $error("target index past list"); // R8
endmodule

// File: rtl/mub_rsp_count.sv
// Module: response counter.
// Counts single-flit acknowledgements while active, saturating at the
// target count. Cleared on load. Assumes n_tgts is constant while active.
module mub_rsp_count #(
    parameter int MAX_TGT = 4,
    localparam int TCW = $clog2(MAX_TGT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           active,
    input  logic           rsp_valid,
    input  logic [TCW-1:0] n_tgts,
    output logic           all_rsp
);
    logic [TCW-1:0] rsp_cnt;

    // Flag completion of the response set.
    always_comb all_rsp = (rsp_cnt == n_tgts);

    // Count responses that arrive while a descriptor is active.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   rsp_cnt <= '0;
        else if (clear)                               rsp_cnt <= '0;
        else if (active && rsp_valid && !all_rsp)     rsp_cnt <= rsp_cnt + TCW'(1);
    end

    AST_RSP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rsp_cnt <= n_tgts)) else $error("response count overflow"); // R9
endmodule

// File: rtl/mcast_upd_builder.sv
// Module: multicast word-update packet builder (top).
// Captures a descriptor on start while idle, emits an (N+2)-flit write
// packet per target, then waits for one response per target and pulses
// done. Assumes 1 <= N <= MAX_WORDS, 1 <= target count <= MAX_TGT, and
// WORD_W >= LINE_W.
module mcast_upd_builder #(
    parameter int              LINE_W    = 30,
    parameter int              WORD_W    = 32,
    parameter int              ADDR_W    = 32,
    parameter int              MAX_WORDS = 16,
    parameter int              MAX_TGT   = 4,
    parameter int              TGT_W     = 6,
    parameter int              TRID_W    = 4,
    parameter logic [ADDR_W-1:0] UPD_ADDR = 32'h0000_0F00,
    localparam int BE_W   = WORD_W / 8,
    localparam int WIW    = $clog2(MAX_WORDS),
    localparam int CNT_W  = $clog2(MAX_WORDS + 1),
    localparam int FW     = $clog2(MAX_WORDS + 2),
    localparam int TCW    = $clog2(MAX_TGT + 1),
    localparam int TIW    = (MAX_TGT > 1) ? $clog2(MAX_TGT) : 1,
    localparam int PLEN_W = $clog2(4 * MAX_WORDS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LINE_W-1:0]         desc_line,
    input  logic [WIW-1:0]            desc_first,
    input  logic [CNT_W-1:0]          desc_nwords,
    input  logic [MAX_WORDS*WORD_W-1:0] desc_data,
    input  logic [MAX_WORDS*BE_W-1:0] desc_be,
    input  logic [TRID_W-1:0]         desc_trid,
    input  logic [TCW-1:0]            desc_ntgt,
    input  logic [MAX_TGT*TGT_W-1:0]  desc_tgts,
    output logic                      busy,
    output logic                      done,
    output logic                      flit_valid,
    input  logic                      flit_ready,
    output logic [ADDR_W-1:0]         flit_addr,
    output logic [1:0]                flit_cmd,
    output logic [PLEN_W-1:0]         flit_plen,
    output logic [TRID_W-1:0]         flit_trdid,
    output logic [TGT_W-1:0]          flit_tgt,
    output logic [WORD_W-1:0]         flit_wdata,
    output logic [BE_W-1:0]           flit_be,
    output logic                      flit_eop,
    input  logic                      rsp_valid
);
    logic [LINE_W-1:0] line_q;
    logic [WIW-1:0]    first_q;
    logic [CNT_W-1:0]  nwords_q;
    logic [TRID_W-1:0] trid_q;
    logic [TCW-1:0]    ntgt_q;
    logic [WORD_W-1:0] word_q [MAX_WORDS];
    logic [BE_W-1:0]   be_q   [MAX_WORDS];
    logic [TGT_W-1:0]  tgt_q  [MAX_TGT];

    logic           load, fire, finish;
    logic           sending, last_flit, all_rsp;
    logic [FW-1:0]  flit_idx;
    logic [TIW-1:0] tgt_idx;
    logic [WIW-1:0] pay_idx;

    // Accept a descriptor only when idle; a flit leaves on valid and ready.
    always_comb begin
        load   = start && !busy;
        fire   = flit_valid && flit_ready;
        finish = busy && !sending && all_rsp;
    end

    // Capture scalar descriptor fields.
    always_ff @(posedge clk) begin
        if (load) begin
            line_q   <= desc_line;
            first_q  <= desc_first;
            nwords_q <= desc_nwords;
            trid_q   <= desc_trid;
            ntgt_q   <= desc_ntgt;
        end
    end

    // Capture payload words, byte enables and target IDs.
    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (load) begin
                word_q[g] <= desc_data[g*WORD_W +: WORD_W];
                be_q[g]   <= desc_be[g*BE_W +: BE_W];
            end
        end
    end
    for (genvar g = 0; g < MAX_TGT; g++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (load) tgt_q[g] <= desc_tgts[g*TGT_W +: TGT_W];
        end
    end

    // Track busy and produce the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (load)        busy <= 1'b1;
            else if (finish) busy <= 1'b0;
        end
    end

    mub_flit_seq #(.MAX_WORDS(MAX_WORDS), .MAX_TGT(MAX_TGT)) seq_i (
        .clk(clk), .rst_n(rst_n), .load(load), .fire(fire),
        .n_words(nwords_q), .n_tgts(ntgt_q), .sending(sending),
        .flit_idx(flit_idx), .tgt_idx(tgt_idx), .last_flit(last_flit)
    );

    mub_rsp_count #(.MAX_TGT(MAX_TGT)) rsp_i (
        .clk(clk), .rst_n(rst_n), .clear(load), .active(busy),
        .rsp_valid(rsp_valid), .n_tgts(ntgt_q), .all_rsp(all_rsp)
    );

    // Select header or payload content for the current flit.
    always_comb begin
        pay_idx    = WIW'(flit_idx - FW'(mub_pkg::HDR_FLITS));
        flit_valid = sending;
        flit_addr  = UPD_ADDR;
        flit_cmd   = mub_pkg::CMD_WRITE;
        flit_plen  = PLEN_W'(nwords_q) << 2;
        flit_trdid = trid_q;
        flit_tgt   = tgt_q[tgt_idx];
        flit_eop   = last_flit;
        if (flit_idx == FW'(0)) begin
            flit_wdata = WORD_W'(line_q);
            flit_be    = '1;
        end else if (flit_idx == FW'(1)) begin
            flit_wdata = WORD_W'(first_q);
            flit_be    = '1;
        end else begin
            flit_wdata = word_q[pay_idx];
            flit_be    = be_q[pay_idx];
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit_wdata)
        && $stable(flit_be) && $stable(flit_eop) && $stable(flit_tgt))) else $error("flit changed under stall"); // R7
    AST_NO_FLIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !flit_valid) else $error("flit while idle"); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !flit_valid)) else $error("done while busy"); // R9
    AST_START_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && flit_valid)) else $error("start not taken"); // R2
endmodule

// File: tb/mcast_upd_builder_tb.sv
module mcast_upd_builder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXW = 16;
    localparam int MAXT = 4;
    localparam logic [31:0] UPD = 32'h0000_0F00;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, flit_ready = 1'b0, rsp_valid = 1'b0;
    logic [29:0]       desc_line = '0;
    logic [3:0]        desc_first = '0;
    logic [4:0]        desc_nwords = '0;
    logic [MAXW*32-1:0] desc_data = '0;
    logic [MAXW*4-1:0] desc_be = '0;
    logic [3:0]        desc_trid = '0;
    logic [2:0]        desc_ntgt = '0;
    logic [MAXT*6-1:0] desc_tgts = '0;
    logic busy, done, flit_valid, flit_eop;
    logic [31:0] flit_addr, flit_wdata;
    logic [1:0]  flit_cmd;
    logic [6:0]  flit_plen;
    logic [3:0]  flit_trdid, flit_be;
    logic [5:0]  flit_tgt;

    int vectors = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mcast_upd_builder dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_line(desc_line),
        .desc_first(desc_first), .desc_nwords(desc_nwords), .desc_data(desc_data),
        .desc_be(desc_be), .desc_trid(desc_trid), .desc_ntgt(desc_ntgt),
        .desc_tgts(desc_tgts), .busy(busy), .done(done), .flit_valid(flit_valid),
        .flit_ready(flit_ready), .flit_addr(flit_addr), .flit_cmd(flit_cmd),
        .flit_plen(flit_plen), .flit_trdid(flit_trdid), .flit_tgt(flit_tgt),
        .flit_wdata(flit_wdata), .flit_be(flit_be), .flit_eop(flit_eop),
        .rsp_valid(rsp_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] word_of(int n, int tc, int j);
        return {8'(n), 8'(tc), 8'(j), 8'hA5};
    endfunction
    function automatic logic [3:0] be_of(int n, int j);
        return 4'((j * 5 + n) & 15);
    endfunction

    task automatic run_case(input int n, input int tc, input bit stall, input bit poke);
        logic [29:0] line = 30'h2AA0_0000 | 30'(n * 97 + tc);
        logic [3:0]  fw = 4'(16 - n);
        logic [3:0]  trid = 4'(n + tc);
        @(negedge clk);
        desc_line = line; desc_first = fw; desc_nwords = 5'(n);
        desc_trid = trid; desc_ntgt = 3'(tc);
        for (int j = 0; j < MAXW; j++) begin
            desc_data[j*32 +: 32] = word_of(n, tc, j);
            desc_be[j*4 +: 4] = be_of(n, j);
        end
        for (int t = 0; t < MAXT; t++) desc_tgts[t*6 +: 6] = 6'(t * 3 + 1);
        start = 1'b1;
        for (int t = 0; t < tc; t++) begin
            for (int k = 0; k < n + 2; k++) begin
                bit acc = 1'b0;
                int iter = 0;
                while (!acc) begin
                    @(negedge clk);
                    start = 1'b0;
                    if (poke && t == 0 && k == 1 && iter == 0) begin
                        start = 1'b1;   // R2: start while busy is ignored
                        desc_trid = ~trid; desc_line = ~line; desc_ntgt = 3'd1;
                    end else if (poke) begin
                        desc_trid = trid; desc_line = line; desc_ntgt = 3'(tc);
                    end
                    flit_ready = stall ? (cyc % 3 != 2) : 1'b1;
                    if (!flit_valid) begin
                        chk(stall, "R8 gap in flit stream", 0, 1);
                    end else begin
                        logic [31:0] ed = (k == 0) ? 32'(line) : (k == 1) ? 32'(fw) : word_of(n, tc, k - 2);
                        logic [3:0]  eb = (k < 2) ? 4'hF : be_of(n, k - 2);
                        chk(flit_wdata == ed, "R3 wdata", 64'(flit_wdata), 64'(ed));
                        chk(flit_be == eb, "R5 byte enables", 64'(flit_be), 64'(eb));
                        chk(flit_eop == (k == n + 1), "R6 eop", 64'(flit_eop), 64'(k == n + 1));
                        chk(flit_plen == 7'(4 * n) && flit_cmd == 2'b10 && flit_addr == UPD,
                            "R4 plen/cmd/addr", {flit_addr, 23'd0, flit_cmd, flit_plen}, {UPD, 23'd0, 2'b10, 7'(4*n)});
                        chk(flit_trdid == trid, "R4 trdid", 64'(flit_trdid), 64'(trid));
                        chk(flit_tgt == 6'(t * 3 + 1), "R8 target order", 64'(flit_tgt), 64'(t * 3 + 1));
                        if (!flit_ready) chk(1'b1, "R7 held under stall", 0, 0);
                        acc = flit_ready;
                    end
                    chk(busy && !done, "R9 busy during send", {busy, done}, 2'b10);
                    iter++;
                end
            end
        end
        start = 1'b0;
        for (int r = 0; r < tc; r++) begin
            @(negedge clk);
            flit_ready = 1'b0;
            chk(busy && !done && !flit_valid, "R9 no done before last response", {busy, done, flit_valid}, 3'b100);
            rsp_valid = 1'b1;
            @(negedge clk);
            rsp_valid = 1'b0;
        end
        chk(!done && busy, "R9 done one cycle late", {busy, done}, 2'b10);
        @(negedge clk);
        chk(done && !busy, "R9 done pulse", {busy, done}, 2'b01);
        @(negedge clk);
        chk(!done && !busy && !flit_valid, "R9 done single cycle", {busy, done, flit_valid}, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!flit_valid && !busy && !done, "R1 reset state", {flit_valid, busy, done}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b1;               // R1: response while idle
        @(negedge clk);
        rsp_valid = 1'b0;
        @(negedge clk);
        chk(!done && !busy, "R1 idle response ignored", {busy, done}, 2'b00);
        for (int n = 1; n <= MAXW; n++)
            for (int tc = 1; tc <= MAXT; tc++) begin
                run_case(n, tc, 1'b0, n == 5 && tc == 3);
                run_case(n, tc, 1'b1, n == 9 && tc == 2);
            end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule